// File: doc/BRIEF.md
# Decoder Node Synchronization Detector

This block watches a sequential decoder for loss of branch (node) alignment. While the decoder runs, its path metrics are periodically renormalized. An unusually high rate of renormalization events means the decoder is working on a misaligned symbol stream. The detector counts those events over an observation window measured in decoded bits. When the count in one window rises above a threshold, the block raises a level out-of-sync flag and emits a single-cycle resync pulse. An external sync-stepping circuit uses that pulse to try the next branch alignment.

The window length is programmable in steps of 256 bits through an 8-bit window setting N. The threshold comes either from an internal 8-bit register or from a set of 8 threshold pins, chosen by a select input. Both internal registers are loaded through simple write strobes that share one data bus. Bus address decode lives outside the block.

Top module: `node_sync_detector`

## Requirements
- R1: A synchronous active-high reset clears `oos` and `resync_pulse`, restarts the window, and loads 0 into both the window register and the threshold register. After reset the window is therefore 256 bits long and a single event exceeds the threshold.
- R2: A window spans exactly 256·(N+1) cycles in which `bit_stb` is high, where N is the window register. Cycles with `bit_stb` low do not advance the window.
- R3: A renormalization event that makes the window's count strictly greater than the active threshold sets `oos` to 1 and drives `resync_pulse` high. Both outputs change on the clock edge that samples the event. The pulse lasts one cycle.
- R4: With `thr_pin_sel` = 0 the active threshold is the internal threshold register. With `thr_pin_sel` = 1 it is `thr_pin`.
- R5: The event count and the bit position both return to zero at every window end. An event sampled in the same cycle as the window's last bit strobe belongs to the ending window.
- R6: `resync_pulse` fires at most once per window, on the first event that takes the count above the threshold. A count equal to the threshold causes no pulse.
- R7: `oos` changes only at a window end or when the threshold is first exceeded. At a window end it takes the value (final count > active threshold), so one clean window clears it.
- R8: The event count saturates at its maximum (511 with the default widths) rather than wrapping. An excess of events is never hidden.
- R9: If N is rewritten to a value whose last bit index lies below the current bit position, the window ends on the next bit strobe.
- R10: `win_wr` loads `cfg_wdata` into the window register and `thr_wr` loads it into the threshold register. The new value takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One decoded bit this cycle |
| renorm_evt | input | 1 | One path-metric renormalization event this cycle |
| win_wr | input | 1 | Load window register from `cfg_wdata` |
| thr_wr | input | 1 | Load threshold register from `cfg_wdata` |
| cfg_wdata | input | 8 | Register write data |
| thr_pin | input | 8 | External threshold |
| thr_pin_sel | input | 1 | 1: use `thr_pin`; 0: use threshold register |
| oos | output | 1 | Out-of-sync level flag |
| resync_pulse | output | 1 | One-cycle request to step the sync position |

## Verification
The hardest situation to reach from the ports is a count that would have wrapped. That needs more events in one window than the counter can hold, which is far more than the window has bits. The stimulus places several hundred event-only cycles, with no bit strobes, at the start of a short window against the largest threshold. It then checks that the flag survives the window end. A second hard case is shrinking N below the current bit position partway through a long window. The stimulus gets there by writing the window register after 600 strobes of a 1024-bit window and checking that the very next strobe closes it.

// File: rtl/nsd_pkg.sv
package nsd_pkg;

    localparam int DEF_N_W      = 8;
    localparam int DEF_THR_W    = 8;
    localparam int DEF_BLK_LOG2 = 8;

    typedef enum logic {
        THR_FROM_REG = 1'b0,
        THR_FROM_PIN = 1'b1
    } thr_src_e;

    typedef struct packed {
        logic exceed;   // count above threshold including this cycle
        logic first;    // first exceed within the current window
    } verdict_t;

    function automatic verdict_t judge(input logic exceed, input logic already_hit);
        verdict_t v;
        v.exceed = exceed;
        v.first  = exceed & ~already_hit;
        return v;
    endfunction

endpackage

// File: rtl/nsd_cfg_regs.sv
module nsd_cfg_regs #(
    parameter int N_W   = nsd_pkg::DEF_N_W,
    parameter int THR_W = nsd_pkg::DEF_THR_W,
    localparam int CFG_W = (N_W > THR_W) ? N_W : THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win_wr,
    input  logic             thr_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [N_W-1:0]   win_n,
    output logic [THR_W-1:0] thr_reg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            win_n   <= '0;
            thr_reg <= '0;
        end else begin
            if (win_wr) win_n   <= cfg_wdata[N_W-1:0];
            if (thr_wr) thr_reg <= cfg_wdata[THR_W-1:0];
        end
    end
endmodule

// File: rtl/nsd_window_timer.sv
module nsd_window_timer #(
    parameter int N_W      = nsd_pkg::DEF_N_W,
    parameter int BLK_LOG2 = nsd_pkg::DEF_BLK_LOG2,
    localparam int BC_W    = N_W + BLK_LOG2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bit_stb,
    input  logic [N_W-1:0] win_n,
    output logic           win_end
);
    logic [BC_W-1:0] bit_cnt;
    logic [BC_W-1:0] last_idx;

    // last index of a window of (N+1) blocks is N*2^BLK_LOG2 + 2^BLK_LOG2 - 1
    assign last_idx = {win_n, {BLK_LOG2{1'b1}}};
    // magnitude compare so a shrunken N cannot be overrun
    assign win_end  = bit_stb && (bit_cnt >= last_idx);

    always_ff @(posedge clk) begin
        if (rst)          bit_cnt <= '0;
        else if (win_end) bit_cnt <= '0;
        else if (bit_stb) bit_cnt <= bit_cnt + BC_W'(1);
    end
endmodule

// File: rtl/nsd_renorm_counter.sv
module nsd_renorm_counter #(
    parameter int CNT_W = nsd_pkg::DEF_THR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_inc
);
    localparam logic [CNT_W-1:0] CEIL = '1;

    always_comb begin
        if (evt && (cnt_q != CEIL)) cnt_inc = cnt_q + CNT_W'(1);
        else                        cnt_inc = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else              cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/nsd_decision.sv
module nsd_decision #(
    parameter int THR_W = nsd_pkg::DEF_THR_W,
    parameter int CNT_W = nsd_pkg::DEF_THR_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_inc,
    input  logic [THR_W-1:0] thr,
    input  logic             win_end,
    output logic             oos,
    output logic             resync_pulse
);
    import nsd_pkg::*;

    logic     hit_q;
    verdict_t vd;

    always_comb begin
        vd = judge(cnt_inc > {{(CNT_W-THR_W){1'b0}}, thr}, hit_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q        <= 1'b0;
            oos          <= 1'b0;
            resync_pulse <= 1'b0;
        end else begin
            resync_pulse <= vd.first;
            if (win_end) begin
                hit_q <= 1'b0;
                oos   <= vd.exceed;
            end else if (vd.first) begin
                hit_q <= 1'b1;
                oos   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/node_sync_detector.sv
module node_sync_detector #(
    parameter int N_W      = nsd_pkg::DEF_N_W,
    parameter int THR_W    = nsd_pkg::DEF_THR_W,
    parameter int BLK_LOG2 = nsd_pkg::DEF_BLK_LOG2,
    localparam int CNT_W   = THR_W + 1,
    localparam int CFG_W   = (N_W > THR_W) ? N_W : THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             renorm_evt,
    input  logic             win_wr,
    input  logic             thr_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [THR_W-1:0] thr_pin,
    input  logic             thr_pin_sel,
    output logic             oos,
    output logic             resync_pulse
);
    import nsd_pkg::*;

    logic [N_W-1:0]   win_n;
    logic [THR_W-1:0] thr_reg;
    logic [THR_W-1:0] thr_act;
    logic             win_end;
    logic [CNT_W-1:0] rn_cnt;
    logic [CNT_W-1:0] rn_inc;
    thr_src_e         src;

    nsd_cfg_regs #(.N_W(N_W), .THR_W(THR_W)) u_regs (
        .clk(clk), .rst(rst), .win_wr(win_wr), .thr_wr(thr_wr),
        .cfg_wdata(cfg_wdata), .win_n(win_n), .thr_reg(thr_reg)
    );

    always_comb begin
        src     = thr_src_e'(thr_pin_sel);
        thr_act = (src == THR_FROM_PIN) ? thr_pin : thr_reg;
    end

    nsd_window_timer #(.N_W(N_W), .BLK_LOG2(BLK_LOG2)) u_timer (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .win_n(win_n), .win_end(win_end)
    );

    nsd_renorm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .evt(renorm_evt), .clear(win_end),
        .cnt_q(rn_cnt), .cnt_inc(rn_inc)
    );

    nsd_decision #(.THR_W(THR_W), .CNT_W(CNT_W)) u_dec (
        .clk(clk), .rst(rst), .cnt_inc(rn_inc), .thr(thr_act), .win_end(win_end),
        .oos(oos), .resync_pulse(resync_pulse)
    );
endmodule

// File: rtl/nsd_checker.sv
module nsd_checker #(
    parameter int CNT_W = nsd_pkg::DEF_THR_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             win_end,
    input logic [CNT_W-1:0] rn_cnt,
    input logic             oos,
    input logic             resync_pulse
);
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!oos && !resync_pulse)); // R1

    AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        resync_pulse |-> oos); // R3

    AST_FLAG_RISE_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(oos) |-> resync_pulse); // R3

    AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(win_end) |-> (rn_cnt == '0)); // R5

    AST_ONE_PER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (resync_pulse && !$past(win_end)) |=> !resync_pulse); // R6

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(win_end) && $past(oos)) |-> oos); // R7

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(win_end) && ($past(rn_cnt) == {CNT_W{1'b1}}))
        |-> (rn_cnt == {CNT_W{1'b1}})); // R8
endmodule

bind node_sync_detector nsd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .win_end(win_end), .rn_cnt(rn_cnt),
    .oos(oos), .resync_pulse(resync_pulse)
);

// File: tb/tb_node_sync_detector.sv
module tb_node_sync_detector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0, renorm_evt = 1'b0, win_wr = 1'b0, thr_wr = 1'b0;
    logic [7:0] cfg_wdata = '0, thr_pin = '0;
    logic       thr_pin_sel = 1'b0;
    logic       oos, resync_pulse;
    int         checks = 0, errors = 0, pulses = 0;

    always #4 clk = ~clk; // 125 MHz

    node_sync_detector dut (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .renorm_evt(renorm_evt),
        .win_wr(win_wr), .thr_wr(thr_wr), .cfg_wdata(cfg_wdata),
        .thr_pin(thr_pin), .thr_pin_sel(thr_pin_sel),
        .oos(oos), .resync_pulse(resync_pulse)
    );

    // columns: N, thr_reg, thr_pin, sel, events, expected oos after window
    localparam int NV = 8;
    localparam int VT [0:NV-1][0:5] = '{
        '{0,   3, 200, 0,   3, 0},   // R6 count equal to threshold
        '{0,   3, 200, 0,   4, 1},   // R3 one above register threshold
        '{1,   3,  10, 1,   4, 0},   // R4 pin threshold in use
        '{1,   3,  10, 1,  11, 1},   // R4
        '{2,   0,   0, 0,   0, 0},   // R7 clean window clears
        '{0, 255,   0, 0, 600, 1},   // R8 would wrap to 88 without saturation
        '{0,  20, 255, 1,  21, 0},   // R4 pin overrides register
        '{3,   5,   0, 1,   1, 1}    // R10 new N and threshold
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic s, input logic e);
        @(negedge clk);
        bit_stb = s; renorm_evt = e;
        @(posedge clk); #1;
        if (resync_pulse) pulses++;
        bit_stb = 1'b0; renorm_evt = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) tick(1'b1, 1'b0);
    endtask

    task automatic wr_win(input int v);
        @(negedge clk); win_wr = 1'b1; cfg_wdata = 8'(v);
        @(posedge clk); #1; win_wr = 1'b0;
    endtask

    task automatic wr_thr(input int v);
        @(negedge clk); thr_wr = 1'b1; cfg_wdata = 8'(v);
        @(posedge clk); #1; thr_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 oos after reset", int'(oos), 0);
        check("R1 pulse after reset", int'(resync_pulse), 0);

        // threshold resets to 0: one event exceeds it
        tick(1'b0, 1'b1);
        check("R3 pulse on sampling edge", int'(resync_pulse), 1);
        check("R1 oos with reset threshold", int'(oos), 1);
        tick(1'b0, 1'b0);
        check("R3 pulse lasts one cycle", int'(resync_pulse), 0);
        // window resets to 256 bits
        strobes(256);
        check("R7 oos kept by exceeded window", int'(oos), 1);
        strobes(255);
        check("R2 window not ended at 255 bits", int'(oos), 1);
        strobes(1);
        check("R2 clean window of 256 clears oos", int'(oos), 0);

        // table-driven windows
        for (int v = 0; v < NV; v++) begin
            wr_win(VT[v][0]);
            wr_thr(VT[v][1]);
            @(negedge clk); thr_pin = 8'(VT[v][2]); thr_pin_sel = VT[v][3][0];
            pulses = 0;
            for (int k = 0; k < VT[v][4]; k++) tick(1'b0, 1'b1);
            strobes(256 * (VT[v][0] + 1));
            check($sformatf("R3/R4/R8 vector %0d oos", v), int'(oos), VT[v][5]);
            check($sformatf("R6 vector %0d pulse count", v), pulses, VT[v][5]);
        end

        // shrinking N below the current position: oos is 1 from the last vector
        wr_win(3);
        strobes(600);
        check("R9 oos held mid window", int'(oos), 1);
        wr_win(1);
        strobes(1);
        check("R9 window closes on next strobe", int'(oos), 0);

        // event on the last bit belongs to the ending window, then counters clear
        wr_win(0);
        wr_thr(0);
        @(negedge clk); thr_pin_sel = 1'b0; thr_pin = 8'd200;
        pulses = 0;
        strobes(255);
        check("R5 no pulse in clean bits", pulses, 0);
        tick(1'b1, 1'b1);
        check("R5 last-bit event pulses", pulses, 1);
        check("R5 last-bit event counted in ending window", int'(oos), 1);
        pulses = 0;
        strobes(256);
        check("R5 count cleared at window end", int'(oos), 0);
        check("R5 no pulse after clear", pulses, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule